// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address of each data beat in an SDRAM read or write burst. When a read or write command arrives it captures the start column, the burst length and the wrap order. The first beat's address appears in the same cycle as the command, so write data can be taken with the command itself. One further address follows on each clock until the burst is done.

Addresses wrap inside the aligned block whose size is the burst length. Two orders are available: sequential, which counts up modulo the length, and interleaved, which XORs the beat number into the low start bits. The column bits above that block do not change during a burst. A burst-stop or precharge request ends a running burst at once and raises an abort flag. A new read or write restarts the sequence in the cycle it appears.

Bank and row tracking, the data path, CAS latency delay and refresh are handled outside this block.

Top module: `burst_col_seq`

## Requirements
- R1: A read (`cmd_i`=1) or write (`cmd_i`=2) command gives `beat_vld_o`=1 and `col_o`=`col_i` in the same cycle, with `abort_o`=0.
- R2: `blen_i` codes 0,1,2,3 select 1,2,4,8 beats on consecutive cycles starting with the command cycle. `last_o` is 1 on the final beat only; a length-1 command has `last_o`=1 in its own cycle.
- R3: With `wrap_i`=0 (sequential), the low log2(L) bits of beat i are (start + i) mod L.
- R4: With `wrap_i`=1 (interleaved), the low log2(L) bits of beat i are start XOR i.
- R5: Column bits at or above log2(L) equal those of the start column on every beat.
- R6: A burst-stop (`cmd_i`=3) or precharge (`cmd_i`=4) while a burst still has beats left gives `abort_o`=1 and `beat_vld_o`=0 in that cycle, and no later beats.
- R7: A burst-stop or precharge with no burst in progress has no effect: `abort_o` and `beat_vld_o` stay 0.
- R8: A read or write during a running burst drops the old burst and starts the new one in that cycle, without `abort_o`.
- R9: While `rst_n` is 0 all outputs are 0, regardless of `cmd_i`. After the synchronous reset no burst is in progress.
- R10: Codes 0,5,6,7 are no-operations. In any cycle without a valid beat, `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 nop, 1 read, 2 write, 3 burst stop, 4 precharge, 5-7 nop |
| col_i | input | COL_W (9) | Start column, used with a read or write |
| blen_i | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 beats |
| wrap_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| col_o | output | COL_W (9) | Column address of the current beat, 0 when no beat is valid |
| beat_vld_o | output | 1 | A beat address is on `col_o` this cycle |
| last_o | output | 1 | This beat is the final beat of a full burst |
| abort_o | output | 1 | The running burst was cut short this cycle |

## Verification
The bench starts bursts at columns whose low bits sit near the top of the window, such as 0x1FD at length 8. A design that carries the sum into the upper bits would change bit 3 or higher there, and one that loses the wrap would never return to the bottom of the window. Interleaved bursts from odd and even starts catch a design that adds where it should XOR. Termination requests are sent both during a burst and while idle: a wrong design either keeps emitting beats after a stop or raises `abort_o` when no burst is running. Back-to-back commands, with bursts of length 1 mixed in, show whether `last_o` is stale and whether the beat counter is reloaded on a restart.

// File: rtl/bcs_pkg.sv
// Package: shared command codes and wrap-order type for the burst column
// sequencer. Assumes a 3-bit command bus; undefined codes act as no-ops.
package bcs_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_RD   = 3'd1,
        CMD_WR   = 3'd2,
        CMD_BST  = 3'd3,
        CMD_PRE  = 3'd4
    } cmd_e;

    typedef enum logic {
        WRAP_SEQ = 1'b0,
        WRAP_INT = 1'b1
    } wrap_e;

    // True for a command that starts a burst.
    function automatic logic is_access(input logic [2:0] c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

    // True for a command that ends a running burst early.
    function automatic logic is_stop(input logic [2:0] c);
        return (c == CMD_BST) || (c == CMD_PRE);
    endfunction

endpackage

// File: rtl/bcs_ctrl.sv
// Burst controller: decodes commands, holds the captured burst parameters
// and the beat counter, and selects either the live command inputs (beat 0)
// or the stored state (later beats) for the address generator.
// Assumes commands are one cycle wide and that the burst length code does
// not exceed the counter width.
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W     = 9,
    parameter int BL_CODE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic [COL_W-1:0]     col_i,
    input  logic [BL_CODE_W-1:0] blen_i,
    input  logic                 wrap_i,
    output logic [COL_W-1:0]     sel_base_o,
    output logic [(2**BL_CODE_W)-2:0] sel_mask_o,
    output logic [(2**BL_CODE_W)-2:0] sel_cnt_o,
    output logic                 sel_mode_o,
    output logic                 beat_o,
    output logic                 last_o,
    output logic                 abort_o
);
    localparam int CNT_W = (2**BL_CODE_W) - 1;

    logic             act_q;
    logic [COL_W-1:0] base_q;
    logic [CNT_W-1:0] mask_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mode_q;

    logic [CNT_W-1:0] cmd_mask;
    logic             start_burst;
    logic             stop_burst;
    logic             beat_last;

    // Window mask for the incoming length code: (2^code) - 1.
    always_comb begin
        cmd_mask = (CNT_W'(1) << blen_i) - CNT_W'(1);
    end

    // Classify this cycle: new burst, early stop, or continuing beat.
    always_comb begin
        start_burst = rst_n && is_access(cmd_i);
        stop_burst  = rst_n && !start_burst && act_q && is_stop(cmd_i);
        beat_last   = start_burst ? (cmd_mask == '0) : (cnt_q == mask_q);
    end

    // Steer command inputs for beat 0, stored state for later beats.
    always_comb begin
        sel_base_o = start_burst ? col_i    : base_q;
        sel_mask_o = start_burst ? cmd_mask : mask_q;
        sel_cnt_o  = start_burst ? '0       : cnt_q;
        sel_mode_o = start_burst ? wrap_i   : mode_q;
        beat_o     = start_burst || (rst_n && act_q && !stop_burst);
        last_o     = beat_o && beat_last;
        abort_o    = stop_burst;
    end

    // Capture burst parameters and advance the beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            base_q <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else if (start_burst) begin
            act_q  <= (cmd_mask != '0);
            base_q <= col_i;
            mask_q <= cmd_mask;
            cnt_q  <= CNT_W'(1);
            mode_q <= wrap_i;
        end else if (stop_burst) begin
            act_q  <= 1'b0;
        end else if (act_q) begin
            act_q  <= !beat_last;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bcs_addr_gen.sv
// Address generator: forms the beat column from the start column, the beat
// number, the window mask and the wrap order. Bits inside the window take
// the wrapped value; bits outside pass the start column through. Output is
// forced to zero when no beat is valid. Purely combinational.
module bcs_addr_gen #(
    parameter int COL_W = 9,
    parameter int CNT_W = 3
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [CNT_W-1:0] mask_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             mode_i,
    input  logic             en_i,
    output logic [COL_W-1:0] col_o
);
    logic [CNT_W-1:0] seq_lo;
    logic [CNT_W-1:0] int_lo;
    logic [CNT_W-1:0] wrap_lo;
    logic [COL_W-1:0] addr;

    // Compute both wrap orders and pick one.
    always_comb begin
        seq_lo  = base_i[CNT_W-1:0] + cnt_i;
        int_lo  = base_i[CNT_W-1:0] ^ cnt_i;
        wrap_lo = mode_i ? int_lo : seq_lo;
    end

    // Per bit: window bits take the wrapped value, others hold the start.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        if (b < CNT_W) begin : g_win
            assign addr[b] = mask_i[b] ? wrap_lo[b] : base_i[b];
        end else begin : g_hold
            assign addr[b] = base_i[b];
        end
    end

    // Blank the bus when no beat is presented.
    always_comb begin
        col_o = en_i ? addr : '0;
    end

endmodule

// File: rtl/burst_col_seq.sv
// Top: SDRAM burst column address sequencer. Beat 0 is presented in the
// command cycle; later beats follow one per clock. Assumes a synchronous
// active-low reset held for at least one clock edge.
module burst_col_seq #(
    parameter int COL_W     = 9,
    parameter int BL_CODE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic [COL_W-1:0]     col_i,
    input  logic [BL_CODE_W-1:0] blen_i,
    input  logic                 wrap_i,
    output logic [COL_W-1:0]     col_o,
    output logic                 beat_vld_o,
    output logic                 last_o,
    output logic                 abort_o
);
    localparam int CNT_W = (2**BL_CODE_W) - 1;

    logic [COL_W-1:0] sel_base;
    logic [CNT_W-1:0] sel_mask;
    logic [CNT_W-1:0] sel_cnt;
    logic             sel_mode;
    logic             beat;

    bcs_ctrl #(.COL_W(COL_W), .BL_CODE_W(BL_CODE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .col_i      (col_i),
        .blen_i     (blen_i),
        .wrap_i     (wrap_i),
        .sel_base_o (sel_base),
        .sel_mask_o (sel_mask),
        .sel_cnt_o  (sel_cnt),
        .sel_mode_o (sel_mode),
        .beat_o     (beat),
        .last_o     (last_o),
        .abort_o    (abort_o)
    );

    bcs_addr_gen #(.COL_W(COL_W), .CNT_W(CNT_W)) u_addr (
        .base_i (sel_base),
        .mask_i (sel_mask),
        .cnt_i  (sel_cnt),
        .mode_i (sel_mode),
        .en_i   (beat),
        .col_o  (col_o)
    );

    assign beat_vld_o = beat;

endmodule

// File: rtl/bcs_checker.sv
// Checker: temporal properties of the sequencer ports, bound to the top.
module bcs_checker #(
    parameter int COL_W     = 9,
    parameter int BL_CODE_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_i,
    input logic [COL_W-1:0]     col_i,
    input logic [BL_CODE_W-1:0] blen_i,
    input logic                 wrap_i,
    input logic [COL_W-1:0]     col_o,
    input logic                 beat_vld_o,
    input logic                 last_o,
    input logic                 abort_o
);
    localparam int CNT_W = (2**BL_CODE_W) - 1;

    logic acc;
    assign acc = (cmd_i == 3'd1) || (cmd_i == 3'd2);

    assert_cmd_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (beat_vld_o && col_o == col_i && !abort_o));

    assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !last_o) |=> (beat_vld_o || abort_o));

    assert_single_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && blen_i == '0) |-> last_o);

    assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !last_o) |=> (acc || !beat_vld_o ||
            col_o[COL_W-1:CNT_W] == $past(col_o[COL_W-1:CNT_W])));

    assert_abort_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> ($past(beat_vld_o && !last_o) && !beat_vld_o));

    assert_after_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !acc) |=> (acc || !beat_vld_o));

    assert_blank_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o |-> (col_o == '0 && !last_o));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .BL_CODE_W(BL_CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .col_i      (col_i),
    .blen_i     (blen_i),
    .wrap_i     (wrap_i),
    .col_o      (col_o),
    .beat_vld_o (beat_vld_o),
    .last_o     (last_o),
    .abort_o    (abort_o)
);

// File: tb/burst_col_seq_test.sv
// Bench: directed corner cases plus seeded random commands, compared each
// cycle against a reference model built from the requirements.
module burst_col_seq_test;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd_i = '0;
    logic [COL_W-1:0] col_i = '0;
    logic [1:0]       blen_i = '0;
    logic             wrap_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o, last_o, abort_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit m_act = 0;
    int m_start = 0, m_bl = 0, m_md = 0, m_idx = 0;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .BL_CODE_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i),
        .blen_i(blen_i), .wrap_i(wrap_i), .col_o(col_o),
        .beat_vld_o(beat_vld_o), .last_o(last_o), .abort_o(abort_o)
    );

    function automatic int exp_col(int start, int bl, int md, int idx);
        int msk, lo;
        msk = (1 << bl) - 1;
        lo  = md ? ((start & msk) ^ idx) : ((start + idx) & msk);
        return (start & ~msk & 511) | lo;
    endfunction

    task automatic check(string tag, int ev, int ecol, int elast, int eab);
        checks++;
        if (beat_vld_o !== ev[0] || col_o !== ecol[COL_W-1:0] ||
            last_o !== elast[0] || abort_o !== eab[0]) begin
            errors++;
            $display("FAIL %s: vld/col/last/abort actual %0b/%03h/%0b/%0b expected %0b/%03h/%0b/%0b",
                     tag, beat_vld_o, col_o, last_o, abort_o,
                     ev[0], ecol[COL_W-1:0], elast[0], eab[0]);
        end
    endtask

    // One cycle: drive at the falling edge, check, advance the model.
    task automatic step(int cmd, int col, int bl, int md);
        bit acc, trm, lst;
        @(negedge clk);
        cmd_i = cmd[2:0]; col_i = col[COL_W-1:0]; blen_i = bl[1:0]; wrap_i = md[0];
        #2;
        acc = (cmd == 1 || cmd == 2);
        trm = (cmd == 3 || cmd == 4);
        if (acc) begin
            check(m_act ? "R8 restart" : "R1 R2 first beat", 1, col, (bl == 0), 0);
            m_act = (bl != 0); m_start = col; m_bl = bl; m_md = md; m_idx = 1;
        end else if (m_act && trm) begin
            check("R6 early stop", 0, 0, 0, 1);
            m_act = 0;
        end else if (m_act) begin
            lst = (m_idx == (1 << m_bl) - 1);
            check(m_md ? "R4 R2 R5 interleaved beat" : "R3 R2 R5 sequential beat",
                  1, exp_col(m_start, m_bl, m_md, m_idx), lst, 0);
            m_idx++;
            m_act = !lst;
        end else begin
            check(trm ? "R7 idle stop" : "R10 idle", 0, 0, 0, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c, r;
        // R9: outputs low during reset even with a read on the bus
        @(negedge clk);
        cmd_i = 3'd1; col_i = 9'h055; blen_i = 2'd3;
        #2;
        check("R9 reset", 0, 0, 0, 0);
        @(negedge clk);
        #2;
        check("R9 reset", 0, 0, 0, 0);
        @(negedge clk);
        cmd_i = 3'd0;
        rst_n = 1'b1;
        #2;
        check("R9 idle after reset", 0, 0, 0, 0);

        // R3 R5: length 8 sequential from 0x1FD, wraps to 0x1F8
        step(1, 'h1FD, 3, 0);
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // R4: length 4 interleaved from 0x0A6
        step(2, 'h0A6, 2, 1);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
        // R4: length 8 interleaved from odd start
        step(1, 'h133, 3, 1);
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0);
        // R6: burst stop mid-burst, then nothing more
        step(1, 'h010, 3, 0);
        step(0, 0, 0, 0);
        step(3, 0, 0, 0);
        step(0, 0, 0, 0);
        // R6: precharge mid-burst
        step(2, 'h1F0, 2, 1);
        step(4, 0, 0, 0);
        step(0, 0, 0, 0);
        // R7: stops while idle
        step(3, 0, 0, 0);
        step(4, 0, 0, 0);
        // R8: restart mid-burst, then length-1 back to back
        step(1, 'h007, 3, 0);
        step(0, 0, 0, 0);
        step(2, 'h0C2, 1, 0);
        step(1, 'h0FF, 0, 1);
        step(2, 'h100, 0, 0);
        step(0, 0, 0, 0);
        // R10: undefined codes behave as no-ops
        step(1, 'h044, 2, 0);
        step(5, 'h1FF, 3, 1);
        step(6, 0, 0, 0);
        step(7, 0, 0, 0);
        step(0, 0, 0, 0);

        // random phase
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            r = $urandom_range(0, 99);
            if (r < 45)      c = 0;
            else if (r < 60) c = 1;
            else if (r < 75) c = 2;
            else if (r < 82) c = 3;
            else if (r < 89) c = 4;
            else             c = $urandom_range(5, 7);
            step(c, $urandom_range(0, 511), $urandom_range(0, 3), $urandom_range(0, 1));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule